// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block turns a data virtual address into a physical address. It looks the address up in a small set-associative table. Each table slot pairs a match word with a translate word, and both are loaded by software through a register port. A request carries the virtual address and four flags: write versus read, supervisor versus user, translation on versus off, and probe-only. One cycle later the block returns the physical address, a cache-inhibit bit and a hit flag. A normal request can also raise a single-cycle exception pulse for a table miss or for a page fault; the pulse carries the virtual address that caused it. The table is never refilled by hardware. Software handles the miss exception and writes the entry itself.

Each match word holds a small usage counter. Every normal hit ages the counters of the other slots in the selected set. A probe request makes no change to any state. On a miss or a permission failure a probe returns address zero, and it raises no exception and no statistics strobe. When translation is off, or when the unit is built as absent, the address passes through unchanged. In that case cache-inhibit is set for the upper half of the address space.

The page size, the number of sets and the number of ways are fixed at elaboration. The number of sets must be at least two.

Top module: `dtlb_translator`

## Requirements
- R1: After reset every match word and translate word reads as zero, so every translated request misses. While reset is active, `rsp_valid`, `exc_miss`, `exc_fault`, `stat_hit` and `stat_miss` are all 0.
- R2: The register address is {kind[1:0], way, set}. The kind field selects the entry type: 0 is the match word, 1 is the translate word, 2 is the read-only configuration word. The configuration word reports log2(sets) in bits [6:3] and (ways-1) in bits [1:0].
- R3: When `req_xlate` is 0, or the unit is built absent, `rsp_paddr` equals the virtual address. `rsp_ci` is then 1 exactly when the address is 0x80000000 or above. `rsp_hit` is 0 and no exception or strobe is raised.
- R4: The set is (vaddr / pagesize) mod sets. The tag compared is vaddr / (pagesize × sets) against match word bits above the page and set bits. A way matches only if match word bit 0 (valid) is 1.
- R5: When more than one way in the set matches, the highest-numbered way supplies the translation.
- R6: On a permitted hit, `rsp_paddr` is the translate word's page number (the bits above the page offset) times pagesize, plus vaddr mod pagesize. `rsp_ci` is translate word bit 1.
- R7: A supervisor read needs translate bit 6 and a supervisor write needs bit 7. A user read needs bit 8 and a user write needs bit 9. A normal request that lacks its bit raises `exc_fault` with `exc_vaddr` set to the virtual address, and still returns the translated address.
- R8: A normal translated request that misses raises `exc_miss` with `exc_vaddr` set to the virtual address. It returns address 0 with `rsp_ci` 0 and `rsp_hit` 0.
- R9: On a normal hit, every other way in the set whose usage counter (match bits [7:6]) is nonzero decreases by one. The hit way's counter is set to 3.
- R10: A probe request changes no usage counter and raises no exception. On a miss or a permission failure it returns address 0 and `rsp_ci` 0.
- R11: A normal translated hit pulses `stat_hit` for one cycle, and a normal translated miss pulses `stat_miss` for one cycle. Probe and pass-through requests pulse neither.
- R12: Every result appears on the cycle after its request, with `rsp_valid` high for exactly that one cycle. Exception and strobe outputs are low in any cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for write access, 0 for read |
| req_super | input | 1 | 1 for supervisor mode |
| req_xlate | input | 1 | Translation enable |
| req_probe | input | 1 | Probe-only request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address {kind, way, set} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_ci | output | 1 | Cache inhibit |
| rsp_hit | output | 1 | Table hit |
| exc_miss | output | 1 | Table-miss exception pulse |
| exc_fault | output | 1 | Page-fault exception pulse |
| exc_vaddr | output | 32 | Virtual address of the last request |
| stat_hit | output | 1 | Hit statistics strobe |
| stat_miss | output | 1 | Miss statistics strobe |

## Verification
All results of a request, including the address, flags, exception pulses and strobes, are due at the first clock edge after the request. The bench drives the request on a falling edge and samples every output on the next falling edge. It then checks on the falling edge after that, with no request pending, that the pulses and `rsp_valid` have dropped. A register write takes effect at the rising edge after it is driven. Register reads are combinational and are sampled just after the address is set. The bench reads usage counters back only after the edge that updates them.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned USE_LSB = 6;
  localparam int unsigned USE_W   = 2;
  localparam logic [USE_W-1:0] USE_MAX = '1;
  localparam int unsigned MV_BIT  = 0;
  localparam int unsigned TCI_BIT = 1;
  localparam int unsigned TSR_BIT = 6;
  localparam int unsigned TSW_BIT = 7;
  localparam int unsigned TUR_BIT = 8;
  localparam int unsigned TUW_BIT = 9;

  typedef enum logic [1:0] {
    RK_MATCH = 2'd0,
    RK_XLATE = 2'd1,
    RK_CFG   = 2'd2,
    RK_NONE  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic          hit;
    logic          ci;
    logic          miss;
    logic          fault;
    logic          hstb;
    logic          mstb;
    logic [AW-1:0] paddr;
  } look_t;
endpackage

// File: rtl/dtlb_store.sv
module dtlb_store
  import dtlb_pkg::*;
#(
  parameter int unsigned NWAYS    = 2,
  parameter int unsigned SET_BITS = 2,
  localparam int unsigned WB      = (NWAYS > 1) ? $clog2(NWAYS) : 1,
  localparam int unsigned NSETS   = 1 << SET_BITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  reg_kind_e                     reg_kind,
  input  logic [WB-1:0]                 reg_way,
  input  logic [SET_BITS-1:0]           reg_set,
  input  logic [AW-1:0]                 wr_data,
  output logic [AW-1:0]                 rd_data,
  input  logic [SET_BITS-1:0]           lk_set,
  output logic [NWAYS-1:0][AW-1:0]      row_mr,
  output logic [NWAYS-1:0][AW-1:0]      row_tr,
  input  logic                          upd_en,
  input  logic [WB-1:0]                 upd_way
);
  logic [AW-1:0] mr_q [NWAYS][NSETS];
  logic [AW-1:0] tr_q [NWAYS][NSETS];
  logic [AW-1:0] mr_d [NWAYS][NSETS];
  logic [AW-1:0] tr_d [NWAYS][NSETS];

  always_comb begin
    for (int w = 0; w < NWAYS; w++) begin
      for (int s = 0; s < NSETS; s++) begin
        mr_d[w][s] = mr_q[w][s];
        tr_d[w][s] = tr_q[w][s];
        if (upd_en && (lk_set == SET_BITS'(s))) begin
          if (upd_way == WB'(w))
            mr_d[w][s][USE_LSB +: USE_W] = USE_MAX;
          else if (mr_q[w][s][USE_LSB +: USE_W] != '0)
            mr_d[w][s][USE_LSB +: USE_W] = mr_q[w][s][USE_LSB +: USE_W] - 1'b1;
        end
        if (wr_en && (reg_way == WB'(w)) && (reg_set == SET_BITS'(s))) begin
          if (reg_kind == RK_MATCH) mr_d[w][s] = wr_data;
          if (reg_kind == RK_XLATE) tr_d[w][s] = wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWAYS; w++)
        for (int s = 0; s < NSETS; s++) begin
          mr_q[w][s] <= '0;
          tr_q[w][s] <= '0;
        end
    end else if (wr_en || upd_en) begin
      for (int w = 0; w < NWAYS; w++)
        for (int s = 0; s < NSETS; s++) begin
          mr_q[w][s] <= mr_d[w][s];
          tr_q[w][s] <= tr_d[w][s];
        end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (reg_way == WB'(w))
        rd_data = (reg_kind == RK_XLATE) ? tr_q[w][reg_set] : mr_q[w][reg_set];
      row_mr[w] = mr_q[w][lk_set];
      row_tr[w] = tr_q[w][lk_set];
    end
  end

  // An update can only target a way whose entry is valid.
  assert_update_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> row_mr[upd_way][MV_BIT]);
endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
  import dtlb_pkg::*;
#(
  parameter int unsigned NWAYS     = 2,
  parameter int unsigned SET_BITS  = 2,
  parameter int unsigned PAGE_BITS = 13,
  parameter bit          PRESENT   = 1'b1,
  localparam int unsigned WB       = (NWAYS > 1) ? $clog2(NWAYS) : 1,
  localparam int unsigned TAG_LSB  = PAGE_BITS + SET_BITS
) (
  input  logic [AW-1:0]            vaddr,
  input  logic                     is_write,
  input  logic                     is_super,
  input  logic                     xlate,
  input  logic                     probe,
  input  logic [NWAYS-1:0][AW-1:0] row_mr,
  input  logic [NWAYS-1:0][AW-1:0] row_tr,
  output look_t                    look,
  output logic                     upd_ok,
  output logic [WB-1:0]            hit_way
);
  logic          hit;
  logic          active;
  logic          allow;
  logic [AW-1:0] tr;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (row_mr[w][MV_BIT] && (row_mr[w][AW-1:TAG_LSB] == vaddr[AW-1:TAG_LSB])) begin
        hit     = 1'b1;
        hit_way = WB'(w);
      end
    end
    tr     = row_tr[hit_way];
    allow  = is_super ? (is_write ? tr[TSW_BIT] : tr[TSR_BIT])
                      : (is_write ? tr[TUW_BIT] : tr[TUR_BIT]);
    active = xlate && PRESENT;
    look   = '0;
    if (!active) begin
      look.paddr = vaddr;
      look.ci    = vaddr[AW-1];
    end else if (hit) begin
      look.hit   = 1'b1;
      look.hstb  = !probe;
      look.fault = !allow && !probe;
      if (allow || !probe) begin
        look.paddr = {tr[AW-1:PAGE_BITS], vaddr[PAGE_BITS-1:0]};
        look.ci    = tr[TCI_BIT];
      end
    end else begin
      look.miss = !probe;
      look.mstb = !probe;
    end
    upd_ok = active && hit && !probe;
  end
endmodule

// File: rtl/dtlb_rsp.sv
module dtlb_rsp
  import dtlb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_probe,
  input  logic          req_xlate,
  input  logic [AW-1:0] req_vaddr,
  input  look_t         look,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_ci,
  output logic          rsp_hit,
  output logic          exc_miss,
  output logic          exc_fault,
  output logic [AW-1:0] exc_vaddr,
  output logic          stat_hit,
  output logic          stat_miss
);
  logic [4:0] pulse_d, pulse_q;

  always_comb begin
    pulse_d = '0;
    if (req_valid) pulse_d = {1'b1, look.miss, look.fault, look.hstb, look.mstb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_paddr <= '0;
      rsp_ci    <= 1'b0;
      rsp_hit   <= 1'b0;
      exc_vaddr <= '0;
    end else if (req_valid) begin
      rsp_paddr <= look.paddr;
      rsp_ci    <= look.ci;
      rsp_hit   <= look.hit;
      exc_vaddr <= req_vaddr;
    end
  end

  assign {rsp_valid, exc_miss, exc_fault, stat_hit, stat_miss} = pulse_q;

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_xlate |=> (rsp_paddr == $past(req_vaddr)) && !rsp_hit
                                && (rsp_ci == $past(req_vaddr[AW-1])));
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_miss |-> !rsp_hit && (rsp_paddr == '0) && !exc_fault);
  assert_probe_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_probe |=> !exc_miss && !exc_fault && !stat_hit && !stat_miss);
  assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !exc_miss && !exc_fault);
endmodule

// File: rtl/dtlb_translator.sv
module dtlb_translator
  import dtlb_pkg::*;
#(
  parameter int unsigned NWAYS     = 2,
  parameter int unsigned SET_BITS  = 2,
  parameter int unsigned PAGE_BITS = 13,
  parameter bit          PRESENT   = 1'b1,
  localparam int unsigned WB       = (NWAYS > 1) ? $clog2(NWAYS) : 1,
  localparam int unsigned RA_W     = 2 + WB + SET_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_vaddr,
  input  logic            req_write,
  input  logic            req_super,
  input  logic            req_xlate,
  input  logic            req_probe,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  output logic            rsp_valid,
  output logic [AW-1:0]   rsp_paddr,
  output logic            rsp_ci,
  output logic            rsp_hit,
  output logic            exc_miss,
  output logic            exc_fault,
  output logic [AW-1:0]   exc_vaddr,
  output logic            stat_hit,
  output logic            stat_miss
);
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  reg_kind_e                kind;
  logic [WB-1:0]            rway;
  logic [SET_BITS-1:0]      rset;
  logic [AW-1:0]            entry_rd, cfg_word;
  logic [NWAYS-1:0][AW-1:0] row_mr, row_tr;
  look_t                    look;
  logic                     upd_ok;
  logic [WB-1:0]            hit_way;

  assign kind     = reg_kind_e'(reg_addr[RA_W-1 -: 2]);
  assign rway     = reg_addr[SET_BITS +: WB];
  assign rset     = reg_addr[SET_BITS-1:0];
  assign cfg_word = (AW'(SET_BITS) << 3) | AW'(NWAYS - 1);
  assign reg_rdata = (kind == RK_CFG) ? cfg_word :
                     (kind == RK_NONE) ? '0 : entry_rd;

  dtlb_store #(.NWAYS(NWAYS), .SET_BITS(SET_BITS)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync),
    .wr_en   (reg_we && (kind == RK_MATCH || kind == RK_XLATE)),
    .reg_kind(kind),
    .reg_way (rway),
    .reg_set (rset),
    .wr_data (reg_wdata),
    .rd_data (entry_rd),
    .lk_set  (req_vaddr[PAGE_BITS +: SET_BITS]),
    .row_mr  (row_mr),
    .row_tr  (row_tr),
    .upd_en  (req_valid && upd_ok),
    .upd_way (hit_way)
  );

  dtlb_lookup #(.NWAYS(NWAYS), .SET_BITS(SET_BITS), .PAGE_BITS(PAGE_BITS),
                .PRESENT(PRESENT)) u_lookup (
    .vaddr   (req_vaddr),
    .is_write(req_write),
    .is_super(req_super),
    .xlate   (req_xlate),
    .probe   (req_probe),
    .row_mr  (row_mr),
    .row_tr  (row_tr),
    .look    (look),
    .upd_ok  (upd_ok),
    .hit_way (hit_way)
  );

  dtlb_rsp u_rsp (
    .clk      (clk),
    .rst_n    (rst_sync),
    .req_valid(req_valid),
    .req_probe(req_probe),
    .req_xlate(req_xlate),
    .req_vaddr(req_vaddr),
    .look     (look),
    .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr),
    .rsp_ci   (rsp_ci),
    .rsp_hit  (rsp_hit),
    .exc_miss (exc_miss),
    .exc_fault(exc_fault),
    .exc_vaddr(exc_vaddr),
    .stat_hit (stat_hit),
    .stat_miss(stat_miss)
  );
endmodule

// File: tb/tb_dtlb_translator.sv
module tb_dtlb_translator;
  logic        clk, rst_n;
  logic        req_valid, req_write, req_super, req_xlate, req_probe;
  logic [31:0] req_vaddr;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rsp_valid, rsp_ci, rsp_hit, exc_miss, exc_fault, stat_hit, stat_miss;
  logic [31:0] rsp_paddr, exc_vaddr;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] m_mr [2][4];
  logic [31:0] m_tr [2][4];

  dtlb_translator dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super), .req_xlate(req_xlate),
    .req_probe(req_probe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci), .rsp_hit(rsp_hit),
    .exc_miss(exc_miss), .exc_fault(exc_fault), .exc_vaddr(exc_vaddr),
    .stat_hit(stat_hit), .stat_miss(stat_miss)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] k, input int w, input int s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {k, w[0], s[1:0]}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (k == 2'd0) m_mr[w][s] = d;
    if (k == 2'd1) m_tr[w][s] = d;
  endtask

  task automatic rchk(input logic [1:0] k, input int w, input int s, input logic [31:0] e, input string rq);
    @(negedge clk);
    reg_addr = {k, w[0], s[1:0]};
    #1;
    chk(reg_rdata === e, rq, reg_rdata, e);
  endtask

  task automatic req(input logic [31:0] va, input bit wr, input bit sup, input bit en,
                     input bit pr, input string rq);
    logic [5:0]  e_flags, a_flags;
    logic [31:0] e_pa, tr;
    bit e_hit, e_ci, e_ms, e_f, e_hs, e_mst, allow;
    int s, hw;
    e_hit = 0; e_ci = 0; e_ms = 0; e_f = 0; e_hs = 0; e_mst = 0; e_pa = 0; hw = -1;
    s = int'(va[14:13]);
    if (!en) begin
      e_pa = va; e_ci = va[31];
    end else begin
      for (int w = 0; w < 2; w++)
        if (m_mr[w][s][0] && (m_mr[w][s][31:15] == va[31:15])) hw = w;
      if (hw >= 0) begin
        tr = m_tr[hw][s];
        allow = sup ? (wr ? tr[7] : tr[6]) : (wr ? tr[9] : tr[8]);
        e_hit = 1; e_hs = !pr; e_f = !allow && !pr;
        if (allow || !pr) begin e_pa = {tr[31:13], va[12:0]}; e_ci = tr[1]; end
      end else begin
        e_ms = !pr; e_mst = !pr;
      end
    end
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr; req_super = sup; req_xlate = en; req_probe = pr;
    @(negedge clk);
    req_valid = 0;
    e_flags = {e_hit, e_ci, e_ms, e_f, e_hs, e_mst};
    a_flags = {rsp_hit, rsp_ci, exc_miss, exc_fault, stat_hit, stat_miss};
    chk(a_flags === e_flags, {rq, " flags/R11"}, 32'(a_flags), 32'(e_flags));
    chk(rsp_paddr === e_pa, {rq, " paddr"}, rsp_paddr, e_pa);
    chk(rsp_valid === 1'b1, "R12 valid", 32'(rsp_valid), 1);
    if (e_ms || e_f) chk(exc_vaddr === va, {rq, " exc addr"}, exc_vaddr, va);
    if (hw >= 0 && en && !pr)
      for (int w = 0; w < 2; w++) begin
        if (w == hw) m_mr[w][s][7:6] = 2'd3;
        else if (m_mr[w][s][7:6] != 0) m_mr[w][s][7:6] = m_mr[w][s][7:6] - 2'd1;
      end
    @(negedge clk);
    chk({rsp_valid, exc_miss, exc_fault, stat_hit, stat_miss} === 5'b0, "R12 pulse drop",
        32'({rsp_valid, exc_miss, exc_fault, stat_hit, stat_miss}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] va, tg;
    clk = 0; rst_n = 0; req_valid = 0; req_vaddr = 0; req_write = 0; req_super = 0;
    req_xlate = 0; req_probe = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    for (int w = 0; w < 2; w++) for (int s = 0; s < 4; s++) begin m_mr[w][s] = 0; m_tr[w][s] = 0; end
    repeat (3) @(negedge clk);
    chk({rsp_valid, exc_miss, exc_fault, stat_hit, stat_miss} === 5'b0, "R1 reset outputs",
        32'({rsp_valid, exc_miss, exc_fault, stat_hit, stat_miss}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int w = 0; w < 2; w++) for (int s = 0; s < 4; s++) begin
      rchk(2'd0, w, s, 0, "R1 match zero");
      rchk(2'd1, w, s, 0, "R1 xlate zero");
    end
    rchk(2'd2, 0, 0, 32'h11, "R2 config");
    // R3 pass-through sweep
    foreach (va_list[i]) begin
      req(va_list[i], i[0], i[1], 0, i[2], "R3");
    end
    req(32'h0000_2000, 0, 1, 1, 0, "R1 miss after reset");
    req(32'h0000_4123, 1, 0, 1, 0, "R8 miss");
    req(32'h0000_4123, 1, 0, 1, 1, "R10 probe miss");
    // Fill every entry
    for (int s = 0; s < 4; s++) for (int w = 0; w < 2; w++) begin
      tg = 32'(s * 2 + w + 1);
      wreg(2'd0, w, s, (tg << 15) | 32'd1);
      wreg(2'd1, w, s, ((32'h40 + tg) << 13) | (32'(w) << 1) | (32'hF << 6));
    end
    for (int s = 0; s < 4; s++) for (int w = 0; w < 2; w++) begin
      tg = 32'(s * 2 + w + 1);
      req((tg << 15) | (32'(s) << 13),          0, 1, 1, 0, "R6");
      req((tg << 15) | (32'(s) << 13) | 32'h1FFF, 1, 0, 1, 0, "R6");
      req((tg << 15) | (32'(s) << 13) | 32'hABC,  0, 0, 1, 0, "R4");
    end
    for (int w = 0; w < 2; w++) for (int s = 0; s < 4; s++)
      rchk(2'd0, w, s, m_mr[w][s], "R9 usage");
    // Wrong set for a tag, then a cleared valid bit
    req((32'd1 << 15) | (32'd1 << 13), 0, 1, 1, 0, "R4 wrong set");
    wreg(2'd0, 0, 2, (32'd5 << 15));
    req((32'd5 << 15) | (32'd2 << 13) | 32'h10, 0, 1, 1, 0, "R4 invalid");
    // Two ways with the same tag
    wreg(2'd0, 1, 0, (32'd1 << 15) | 32'd1);
    req((32'd1 << 15) | 32'h55, 0, 1, 1, 0, "R5");
    rchk(2'd0, 0, 0, m_mr[0][0], "R9 dup usage");
    // Permission sweep on way 0 set 1 (tag 3)
    for (int p = 0; p < 16; p++) begin
      wreg(2'd1, 0, 1, (32'h77 << 13) | 32'h2 | (32'(p) << 6));
      for (int c = 0; c < 8; c++)
        req((32'd3 << 15) | (32'd1 << 13) | 32'h3C, c[0], c[1], 1, c[2], c[2] ? "R10" : "R7");
    end
    // Probe leaves usage counters untouched
    req((32'd4 << 15) | (32'd1 << 13), 0, 1, 1, 1, "R10 probe hit");
    rchk(2'd0, 0, 1, m_mr[0][1], "R10 usage w0");
    rchk(2'd0, 1, 1, m_mr[1][1], "R10 usage w1");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  logic [31:0] va_list [8] = '{32'h0, 32'h1234, 32'h7FFF_FFFF, 32'h8000_0000,
                               32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0001_E000, 32'h8765_4321};
endmodule